// File: doc/BRIEF.md
# Frame-Synchronous Codec Link Sequencer

This block drives a short serial control link to a companion sub-band codec, once per audio frame. A frame sync pulse makes it read the codec's status word, and the result is held on a status output for the allocation stage. When the allocation stage presents a finished allocation table, a settings word and a scale index table, the block takes a snapshot of all three. It then sends the allocation table as eight 16-bit data units. Before every unit except the first, it re-reads the codec status until the codec reports that it is ready to receive. After the last unit it sends the settings word and, unless disabled, the scale index units.

A host may hand over an extended settings word at any time. That word is sent on the link at the first free slot. In decoding mode the block only reads status on each frame sync. If a frame sync arrives while the current frame's transfers are still pending, the block drops them and raises a sticky overrun flag.

Top module: `alloc_xfer_seq`

## Requirements
- R1: A pulse on `fsync` causes a status read (link mode 2'b00, `lk_doe` low while enable is high) before any other word of that frame. The word read is shown on `codec_status` from the cycle after the read ends.
- R2: Each word occupies exactly 32 cycles with `lk_en` high. `lk_clk` is low on even cycles and high on odd cycles, counted from 0. Bits move MSB first, and the receiver samples in the odd cycles. At least one cycle with `lk_en` low separates two words, and `lk_mode` is constant while `lk_en` is high.
- R3: The link mode encodes the word type: 2'b00 for a status read, 2'b01 for a data unit (allocation or scale index), 2'b10 for settings and 2'b11 for extended settings. `lk_doe` is high for every write type.
- R4: An `alloc_valid` pulse while the block waits for allocation results captures `alloc_tbl`, `set_word`, `scf_tbl` and `scf_off`. Unit k is `alloc_tbl[16k+15:16k]`, sent for k = 0 to 7 in rising order. Unit 0 is the first frame word after the frame status read.
- R5: Before units 1 to 7, status reads repeat until bit 0 of the returned word is 1, and then the unit is sent. No such poll precedes unit 0 or follows unit 7.
- R6: The settings word directly follows unit 7. When the captured `scf_off` is 0, twelve scale units `scf_tbl[16j+15:16j]` (j ascending) follow it; otherwise the frame ends after the settings word.
- R7: `ext_valid` is accepted while `ext_rdy` is high, and `ext_rdy` is then low until that word starts on the link. The accepted word is the next word sent, with mode 2'b11, yielding only to a pending frame status read. `ext_valid` while `ext_rdy` is low has no effect.
- R8: With `decode` high, a frame sync yields only the status read, and `alloc_valid` has no effect.
- R9: A frame sync arriving before the frame's last word has finished sets `overrun`, which stays set until reset. The word in flight completes, the remaining frame words are dropped, and the next word is the new status read. `alloc_valid` outside the waiting phase has no effect.
- R10: After reset `lk_en` is low, `overrun` is 0, `ext_rdy` is 1 and `codec_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync pulse |
| decode | input | 1 | 1 selects decoding mode |
| scf_off | input | 1 | 1 suppresses scale index units |
| alloc_valid | input | 1 | Allocation results ready pulse |
| alloc_tbl | input | 128 | Allocation table, 4 bits per sub-band |
| set_word | input | 16 | Settings word |
| scf_tbl | input | 192 | Scale index table, 6 bits per sub-band |
| ext_valid | input | 1 | Host extended settings strobe |
| ext_word | input | 16 | Host extended settings word |
| ext_rdy | output | 1 | Extended settings slot free |
| lk_din | input | 1 | Link data from codec |
| lk_en | output | 1 | Link enable |
| lk_clk | output | 1 | Link bit clock |
| lk_mode | output | 2 | Link word type |
| lk_dout | output | 1 | Link data to codec |
| lk_doe | output | 1 | Link data drive enable |
| codec_status | output | 16 | Last status word read |
| overrun | output | 1 | Sticky frame overrun flag |

## Verification
The bench answers each status read with a chosen ready pattern. Some units get several not-ready polls and others get none, so a design that skipped the poll or treated bit 0 inverted would send units early or stall. An extended settings word is injected in the middle of an allocation unit, and a second one is offered while the slot is busy. A design that queued behind the frame, or latched the second word, would show the wrong word order or value. A frame sync is forced during a poll, so a design that aborted the word on the wire, kept sending the stale frame or forgot the overrun flag would be caught, as would one that ignored `scf_off` or acted on allocation results in decoding mode.

// File: rtl/alloc_xfer_pkg.sv
package alloc_xfer_pkg;

    typedef enum logic [1:0] {
        MD_STAT = 2'b00,
        MD_UNIT = 2'b01,
        MD_SET  = 2'b10,
        MD_EXT  = 2'b11
    } lk_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT,
        PH_ALLOC,
        PH_POLL,
        PH_SET,
        PH_SCF
    } phase_e;

    typedef enum logic [2:0] {
        XK_STAT,
        XK_POLL,
        XK_ALLOC,
        XK_SET,
        XK_SCF,
        XK_EXT
    } xkind_e;

endpackage

// File: rtl/xfer_link.sv
module xfer_link
    import alloc_xfer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  lk_mode_e       mode_i,
    input  logic [W-1:0]   wdata_i,
    input  logic           din_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [W-1:0]   rdata_o,
    output logic           lk_en_o,
    output logic           lk_clk_o,
    output logic           lk_dout_o,
    output logic           lk_doe_o,
    output lk_mode_e       lk_mode_o
);
    localparam int CW = $clog2(2 * W);
    localparam logic [CW-1:0] LAST = CW'(2 * W - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        lk_mode_e      mode;
        logic [W-1:0]  sh;
    } link_t;

    link_t d, q;

    // the word ends on the last odd (sampling) cycle
    assign done_o  = q.busy && (q.cnt == LAST);
    assign rdata_o = {q.sh[W-2:0], din_i};

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (start_i) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.mode = mode_i;
                d.sh   = wdata_i;
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt[0]) begin
                d.sh = {q.sh[W-2:0], (q.mode == MD_STAT) ? din_i : 1'b0};
            end
            if (done_o) begin
                d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{busy: 1'b0, cnt: '0, mode: MD_STAT, sh: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o    = q.busy;
    assign lk_en_o   = q.busy;
    assign lk_clk_o  = q.busy && q.cnt[0];
    assign lk_doe_o  = q.busy && (q.mode != MD_STAT);
    assign lk_dout_o = q.busy && (q.mode != MD_STAT) && q.sh[W-1];
    assign lk_mode_o = q.busy ? q.mode : MD_STAT;

endmodule

// File: rtl/ext_hold.sv
module ext_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid_i,
    input  logic [W-1:0] word_i,
    input  logic         take_i,
    output logic         rdy_o,
    output logic         pend_o,
    output logic [W-1:0] word_o
);
    typedef struct packed {
        logic         pend;
        logic [W-1:0] word;
    } hold_t;

    hold_t d, q;

    always_comb begin
        d = q;
        if (take_i) begin
            d.pend = 1'b0;
        end
        if (valid_i && !q.pend) begin
            d.pend = 1'b1;
            d.word = word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdy_o  = !q.pend;
    assign pend_o = q.pend;
    assign word_o = q.word;

endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import alloc_xfer_pkg::*;
#(
    parameter int W          = 16,
    parameter int NBANDS     = 32,
    parameter int ALLOC_BITS = 4,
    parameter int SCF_BITS   = 6,
    parameter int READY_BIT  = 0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          fsync_i,
    input  logic                          decode_i,
    input  logic                          scf_off_i,
    input  logic                          alloc_valid_i,
    input  logic [NBANDS*ALLOC_BITS-1:0]  alloc_tbl_i,
    input  logic [W-1:0]                  set_word_i,
    input  logic [NBANDS*SCF_BITS-1:0]    scf_tbl_i,
    input  logic                          ext_pend_i,
    input  logic [W-1:0]                  ext_word_i,
    input  logic                          lk_busy_i,
    input  logic                          lk_done_i,
    input  logic [W-1:0]                  lk_rdata_i,
    output logic                          start_o,
    output lk_mode_e                      start_mode_o,
    output logic [W-1:0]                  wdata_o,
    output logic                          ext_take_o,
    output logic                          overrun_o,
    output logic [W-1:0]                  status_o
);
    localparam int AU = NBANDS * ALLOC_BITS / W;
    localparam int SU = NBANDS * SCF_BITS / W;
    localparam int AW = AU * W;
    localparam int SW = SU * W;
    localparam int IW = $clog2(((AU > SU) ? AU : SU) + 1);
    localparam logic [IW-1:0] A_LAST = IW'(AU - 1);
    localparam logic [IW-1:0] S_LAST = IW'(SU - 1);

    typedef struct packed {
        phase_e        phase;
        logic [IW-1:0] idx;
        logic          sreq;
        logic          live;
        xkind_e        kind;
        logic [AW-1:0] tbl;
        logic [W-1:0]  setw;
        logic [SW-1:0] scf;
        logic          scf_on;
        logic          ovr;
        logic [W-1:0]  stat;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d            = q;
        start_o      = 1'b0;
        start_mode_o = MD_STAT;
        wdata_o      = '0;
        ext_take_o   = 1'b0;

        // a word finished on the link
        if (lk_done_i) begin
            if (q.kind == XK_STAT || q.kind == XK_POLL) begin
                d.stat = lk_rdata_i;
            end
            if (q.live) begin
                case (q.kind)
                    XK_POLL: begin
                        if (lk_rdata_i[READY_BIT]) d.phase = PH_ALLOC;
                    end
                    XK_ALLOC: begin
                        if (q.idx == A_LAST) begin
                            d.phase = PH_SET;
                            d.idx   = '0;
                        end else begin
                            d.phase = PH_POLL;
                            d.idx   = q.idx + 1'b1;
                        end
                    end
                    XK_SET: begin
                        d.phase = q.scf_on ? PH_SCF : PH_IDLE;
                        d.idx   = '0;
                    end
                    XK_SCF: begin
                        if (q.idx == S_LAST) d.phase = PH_IDLE;
                        else                 d.idx   = q.idx + 1'b1;
                    end
                    default: ;
                endcase
            end
        end

        // choose the next word while the link is free
        if (!lk_busy_i) begin
            if (q.sreq) begin
                start_o = 1'b1;
                d.sreq  = 1'b0;
                d.kind  = XK_STAT;
            end else if (ext_pend_i) begin
                start_o      = 1'b1;
                start_mode_o = MD_EXT;
                wdata_o      = ext_word_i;
                ext_take_o   = 1'b1;
                d.kind       = XK_EXT;
            end else begin
                case (q.phase)
                    PH_ALLOC: begin
                        start_o      = 1'b1;
                        start_mode_o = MD_UNIT;
                        wdata_o      = q.tbl[int'(q.idx) * W +: W];
                        d.kind       = XK_ALLOC;
                        d.live       = 1'b1;
                    end
                    PH_POLL: begin
                        start_o = 1'b1;
                        d.kind  = XK_POLL;
                        d.live  = 1'b1;
                    end
                    PH_SET: begin
                        start_o      = 1'b1;
                        start_mode_o = MD_SET;
                        wdata_o      = q.setw;
                        d.kind       = XK_SET;
                        d.live       = 1'b1;
                    end
                    PH_SCF: begin
                        start_o      = 1'b1;
                        start_mode_o = MD_UNIT;
                        wdata_o      = q.scf[int'(q.idx) * W +: W];
                        d.kind       = XK_SCF;
                        d.live       = 1'b1;
                    end
                    default: ;
                endcase
            end
        end

        // frame boundary overrides everything that belongs to the old frame
        if (fsync_i) begin
            d.sreq = 1'b1;
            d.live = 1'b0;
            d.idx  = '0;
            if (q.phase != PH_IDLE) d.ovr = 1'b1;
            d.phase = decode_i ? PH_IDLE : PH_WAIT;
        end else if (alloc_valid_i && q.phase == PH_WAIT) begin
            d.tbl    = alloc_tbl_i;
            d.setw   = set_word_i;
            d.scf    = scf_tbl_i;
            d.scf_on = !scf_off_i;
            d.phase  = PH_ALLOC;
            d.idx    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{phase: PH_IDLE, idx: '0, sreq: 1'b0, live: 1'b0, kind: XK_STAT,
                   tbl: '0, setw: '0, scf: '0, scf_on: 1'b0, ovr: 1'b0, stat: '0};
        end else begin
            q <= d;
        end
    end

    assign overrun_o = q.ovr;
    assign status_o  = q.stat;

endmodule

// File: rtl/alloc_xfer_seq.sv
module alloc_xfer_seq
    import alloc_xfer_pkg::*;
#(
    parameter  int UNIT_W     = 16,
    parameter  int NBANDS     = 32,
    parameter  int ALLOC_BITS = 4,
    parameter  int SCF_BITS   = 6,
    parameter  int READY_BIT  = 0,
    localparam int AW         = NBANDS * ALLOC_BITS,
    localparam int SW         = NBANDS * SCF_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fsync,
    input  logic              decode,
    input  logic              scf_off,
    input  logic              alloc_valid,
    input  logic [AW-1:0]     alloc_tbl,
    input  logic [UNIT_W-1:0] set_word,
    input  logic [SW-1:0]     scf_tbl,
    input  logic              ext_valid,
    input  logic [UNIT_W-1:0] ext_word,
    output logic              ext_rdy,
    input  logic              lk_din,
    output logic              lk_en,
    output logic              lk_clk,
    output logic [1:0]        lk_mode,
    output logic              lk_dout,
    output logic              lk_doe,
    output logic [UNIT_W-1:0] codec_status,
    output logic              overrun
);
    logic              start, busy, done, ext_take, ext_pend;
    lk_mode_e          start_mode, mode_out;
    logic [UNIT_W-1:0] wdata, rdata, ext_q;

    ext_hold #(.W(UNIT_W)) u_ext (
        .clk(clk), .rst(rst), .valid_i(ext_valid), .word_i(ext_word),
        .take_i(ext_take), .rdy_o(ext_rdy), .pend_o(ext_pend), .word_o(ext_q)
    );

    frame_seq #(
        .W(UNIT_W), .NBANDS(NBANDS), .ALLOC_BITS(ALLOC_BITS),
        .SCF_BITS(SCF_BITS), .READY_BIT(READY_BIT)
    ) u_seq (
        .clk(clk), .rst(rst), .fsync_i(fsync), .decode_i(decode),
        .scf_off_i(scf_off), .alloc_valid_i(alloc_valid), .alloc_tbl_i(alloc_tbl),
        .set_word_i(set_word), .scf_tbl_i(scf_tbl), .ext_pend_i(ext_pend),
        .ext_word_i(ext_q), .lk_busy_i(busy), .lk_done_i(done), .lk_rdata_i(rdata),
        .start_o(start), .start_mode_o(start_mode), .wdata_o(wdata),
        .ext_take_o(ext_take), .overrun_o(overrun), .status_o(codec_status)
    );

    xfer_link #(.W(UNIT_W)) u_link (
        .clk(clk), .rst(rst), .start_i(start), .mode_i(start_mode), .wdata_i(wdata),
        .din_i(lk_din), .busy_o(busy), .done_o(done), .rdata_o(rdata),
        .lk_en_o(lk_en), .lk_clk_o(lk_clk), .lk_dout_o(lk_dout),
        .lk_doe_o(lk_doe), .lk_mode_o(mode_out)
    );

    assign lk_mode = mode_out;

endmodule

// File: rtl/alloc_xfer_seq_chk.sv
module alloc_xfer_seq_chk #(
    parameter int UNIT_W = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       lk_en,
    input logic       lk_clk,
    input logic [1:0] lk_mode,
    input logic       lk_doe,
    input logic       overrun
);
    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)        run_q <= '0;
        else if (lk_en) run_q <= run_q + 16'd1;
        else            run_q <= '0;
    end

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !lk_en |-> (!lk_clk && !lk_doe));

    assert_read_released_R1: assert property (@(posedge clk) disable iff (rst)
        (lk_en && lk_mode == 2'b00) |-> !lk_doe);

    assert_write_drives_R3: assert property (@(posedge clk) disable iff (rst)
        (lk_en && lk_mode != 2'b00) |-> lk_doe);

    assert_clk_first_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(lk_en) |-> !lk_clk);

    assert_clk_alt_R2: assert property (@(posedge clk) disable iff (rst)
        (lk_en && $past(lk_en)) |-> (lk_clk != $past(lk_clk)));

    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (lk_en && $past(lk_en)) |-> (lk_mode == $past(lk_mode)));

    assert_word_len_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(lk_en) |-> (run_q == 16'(2 * UNIT_W)));

    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

bind alloc_xfer_seq alloc_xfer_seq_chk #(.UNIT_W(UNIT_W)) u_chk (
    .clk(clk), .rst(rst), .lk_en(lk_en), .lk_clk(lk_clk),
    .lk_mode(lk_mode), .lk_doe(lk_doe), .overrun(overrun)
);

// File: tb/alloc_xfer_seq_test.sv
`timescale 1ns/1ps
module alloc_xfer_seq_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fsync = 1'b0, decode = 1'b0, scf_off = 1'b0, alloc_valid = 1'b0;
    logic [127:0] alloc_tbl = '0;
    logic [15:0]  set_word = '0;
    logic [191:0] scf_tbl = '0;
    logic ext_valid = 1'b0;
    logic [15:0] ext_word = '0;
    logic lk_din = 1'b0;
    logic ext_rdy, lk_en, lk_clk, lk_dout, lk_doe, overrun;
    logic [1:0] lk_mode;
    logic [15:0] codec_status;

    always #2.5 clk = ~clk;

    alloc_xfer_seq uut (
        .clk(clk), .rst(rst), .fsync(fsync), .decode(decode), .scf_off(scf_off),
        .alloc_valid(alloc_valid), .alloc_tbl(alloc_tbl), .set_word(set_word),
        .scf_tbl(scf_tbl), .ext_valid(ext_valid), .ext_word(ext_word),
        .ext_rdy(ext_rdy), .lk_din(lk_din), .lk_en(lk_en), .lk_clk(lk_clk),
        .lk_mode(lk_mode), .lk_dout(lk_dout), .lk_doe(lk_doe),
        .codec_status(codec_status), .overrun(overrun)
    );

    int checks = 0, fails = 0, n_started = 0, mcnt = 0;
    bit in_tx = 1'b0, done_flag = 1'b0;
    logic [17:0] expq[$];
    logic [17:0] cur = '0;
    logic [15:0] got = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] m);
        case (m)
            2'b00: return "R5";
            2'b01: return "R4";
            2'b10: return "R6";
            default: return "R7";
        endcase
    endfunction

    // behavioural link partner: pops the expected word, answers reads, compares writes
    always @(negedge clk) begin
        if (!rst) begin
            if (lk_en) begin
                if (!in_tx) begin
                    in_tx = 1'b1;
                    mcnt = 0;
                    n_started++;
                    got = '0;
                    if (expq.size() == 0) begin
                        chk(1'b0, "R9", "unexpected word on link", {30'd0, lk_mode}, 32'hFFFF);
                        cur = {lk_mode, 16'h0};
                    end else begin
                        cur = expq.pop_front();
                        chk(lk_mode == cur[17:16], "R3", "word type", {30'd0, lk_mode}, {30'd0, cur[17:16]});
                    end
                end else begin
                    mcnt++;
                end
                chk(lk_clk == mcnt[0], "R2", "bit clock phase", {31'd0, lk_clk}, {31'd0, mcnt[0]});
                chk(lk_doe == (cur[17:16] != 2'b00), "R1", "drive enable", {31'd0, lk_doe},
                    {31'd0, (cur[17:16] != 2'b00)});
                if (cur[17:16] == 2'b00 && mcnt < 32) lk_din <= cur[15 - mcnt/2];
                if (mcnt[0]) got = {got[14:0], lk_dout};
                if (mcnt == 31 && cur[17:16] != 2'b00)
                    chk(got == cur[15:0], req_of(cur[17:16]), "written word", {16'd0, got}, {16'd0, cur[15:0]});
            end else if (in_tx) begin
                in_tx = 1'b0;
                lk_din <= 1'b0;
                chk(mcnt == 31, "R2", "word length", mcnt + 1, 32);
                if (cur[17:16] == 2'b00)
                    chk(codec_status == cur[15:0], "R1", "status latched", {16'd0, codec_status}, {16'd0, cur[15:0]});
            end
        end
    end

    task automatic finish_all();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_all();
    end

    task automatic pulse_fsync();
        @(negedge clk); fsync = 1'b1;
        @(negedge clk); fsync = 1'b0;
    endtask

    task automatic give_alloc(input logic [7:0] seed, input bit off);
        @(negedge clk);
        for (int k = 0; k < 8; k++) alloc_tbl[k*16 +: 16] = {seed, 8'(k * 17 + 3)};
        for (int j = 0; j < 12; j++) scf_tbl[j*16 +: 16] = {8'(seed ^ 8'h5A), 8'(j * 9 + 1)};
        set_word = {8'hC0, seed};
        scf_off = off;
        alloc_valid = 1'b1;
        @(negedge clk); alloc_valid = 1'b0;
    endtask

    // expected words of one frame, given the ready pattern the partner will answer
    task automatic push_frame(input bit with_stat, input logic [15:0] sbase,
                              input logic [7:0] seed, input bit off);
        if (with_stat) expq.push_back({2'b00, sbase});
        for (int k = 0; k < 8; k++) begin
            if (k > 0) begin
                for (int p = 0; p < k % 3; p++) expq.push_back({2'b00, sbase & 16'hFFFE});
                expq.push_back({2'b00, sbase | 16'h0001});
            end
            expq.push_back({2'b01, seed, 8'(k * 17 + 3)});
        end
        expq.push_back({2'b10, 8'hC0, seed});
        if (!off) for (int j = 0; j < 12; j++) expq.push_back({2'b01, 8'(seed ^ 8'h5A), 8'(j * 9 + 1)});
    endtask

    task automatic drain(input string req);
        int t = 0;
        while ((expq.size() != 0 || in_tx) && t < 20000) begin
            @(negedge clk); t++;
        end
        repeat (100) @(negedge clk);
        chk(expq.size() == 0 && !lk_en, req, "all expected words sent, link idle",
            expq.size(), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R10 reset state
        chk(lk_en == 1'b0, "R10", "enable after reset", {31'd0, lk_en}, 0);
        chk(overrun == 1'b0, "R10", "overrun after reset", {31'd0, overrun}, 0);
        chk(ext_rdy == 1'b1, "R10", "ext slot after reset", {31'd0, ext_rdy}, 1);
        chk(codec_status == 16'h0, "R10", "status after reset", {16'd0, codec_status}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // frame with scale units; R4 R5 R6, plus R7 extended settings in mid-unit
        push_frame(1'b1, 16'h3A40, 8'h11, 1'b0);
        pulse_fsync();
        give_alloc(8'h11, 1'b0);
        while (!(n_started == 2 && in_tx)) @(negedge clk);
        repeat (4) @(negedge clk);
        ext_word = 16'h0E51; ext_valid = 1'b1;
        expq.push_front({2'b11, 16'h0E51});
        @(negedge clk);
        chk(ext_rdy == 1'b0, "R7", "slot busy after accept", {31'd0, ext_rdy}, 0);
        ext_word = 16'hBAD0;          // R7: offered while busy, must be ignored
        @(negedge clk); ext_valid = 1'b0;
        drain("R6");
        chk(ext_rdy == 1'b1, "R7", "slot free after send", {31'd0, ext_rdy}, 1);
        chk(overrun == 1'b0, "R9", "no overrun on clean frame", {31'd0, overrun}, 0);

        // R9: results outside the waiting phase are ignored
        give_alloc(8'h77, 1'b0);
        drain("R9");

        // frame without scale units (R6)
        push_frame(1'b1, 16'h5C21, 8'h22, 1'b1);
        pulse_fsync();
        give_alloc(8'h22, 1'b1);
        drain("R6");
        chk(overrun == 1'b0, "R9", "no overrun after finished frame", {31'd0, overrun}, 0);

        // R8 decoding mode: status read only
        decode = 1'b1;
        expq.push_back({2'b00, 16'h9103});
        pulse_fsync();
        give_alloc(8'h33, 1'b0);
        drain("R8");
        chk(codec_status == 16'h9103, "R8", "decode status", {16'd0, codec_status}, 32'h9103);
        chk(overrun == 1'b0, "R8", "no overrun in decode", {31'd0, overrun}, 0);
        decode = 1'b0;

        // R9 overrun: frame sync during the poll before unit 1
        begin
            int base;
            base = n_started;
            push_frame(1'b1, 16'h7E60, 8'h44, 1'b0);
            pulse_fsync();
            give_alloc(8'h44, 1'b0);
            while (!(n_started == base + 3 && in_tx)) @(negedge clk);
            repeat (3) @(negedge clk);
            expq.delete();
            expq.push_back({2'b00, 16'h2B14});
            pulse_fsync();
            chk(overrun == 1'b1, "R9", "overrun raised", {31'd0, overrun}, 1);
            drain("R9");
            push_frame(1'b0, 16'h2B14, 8'h55, 1'b1);
            give_alloc(8'h55, 1'b1);
            drain("R9");
            chk(overrun == 1'b1, "R9", "overrun sticky", {31'd0, overrun}, 1);
        end

        finish_all();
    end
endmodule